// File: doc/BRIEF.md
# USB Endpoint Handshake and Data-Toggle Controller

This block holds the per-endpoint control state of a USB device controller: the receive and transmit enables, endpoint types, stall flags and data toggles. It answers each decoded bus event with a handshake decision. A small register port configures each endpoint. Decoded token events arrive on a valid/ready stream, each tagged with an endpoint number and, for data packets, the received data PID. For each event the block sends back one response on a second valid/ready stream. The response carries the handshake to send, a flag saying whether the received data is kept or dropped, and the data PID that applies.

A control endpoint that has been stalled is released by hardware when a SETUP packet arrives. The release persists while the endpoint's setup-status input stays high, so firmware cannot re-stall it before it has handled the setup request. A test-only inhibit bit makes the receive side keep every data packet without checking or advancing the toggle. Packet encoding, CRC, buffer storage and DMA are handled elsewhere. The buffer side reports only whether it has room for received data or has transmit data waiting.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset every endpoint word reads 0 (disabled, control type, not stalled, inhibit off, both expected PIDs DATA0), and no response is pending.
- R2: Each endpoint word has this layout: bit0 receive enable, bits2:1 receive type, bit3 receive inhibit, bit4 receive stall, bit5 receive toggle reset, bit8 transmit enable, bits10:9 transmit type, bit11 transmit stall, bit12 transmit toggle reset. The type codes are 0 control, 1 isochronous, 2 bulk and 3 interrupt. The toggle-reset bits and all other bits always read 0.
- R3: A token for a direction whose enable bit is 0 gets response code NONE (0), its data is not kept, and no toggle changes.
- R4: With inhibit off, an OUT data packet (kind 1) on a non-isochronous endpoint with buffer room gets ACK (1). If its PID (0 = DATA0, 1 = DATA1) equals the expected receive toggle, the data is kept and the toggle flips. Otherwise the data is dropped and the toggle is unchanged. The response PID of an OUT packet is the expected receive toggle before the packet.
- R5: With inhibit on, an OUT data packet that would otherwise be ACKed is kept whatever its PID, and the receive toggle does not change.
- R6: Writing 1 to a toggle-reset bit sets that direction's expected PID to DATA0.
- R7: While a stall bit is 1, OUT packets (receive stall) and IN tokens (kind 2, transmit stall) on a non-isochronous endpoint get STALL (3), until software writes the bit to 0.
- R8: A SETUP token (kind 0) on an enabled endpoint whose receive type is control gets ACK with data kept. It clears each stall bit whose direction has control type, and it sets both expected PIDs to DATA1. A SETUP token on any other endpoint gets NONE and changes no state.
- R9: While an endpoint's setup-status input is 1, each stall bit of a control-type direction is held at 0, and writes of 1 to it are overridden. Once the input is 0, a write of 1 takes effect.
- R10: An isochronous direction sends no handshake. OUT gets NONE, and its data is kept exactly when buffer room exists. IN gets DATA (4) with PID DATA0 when transmit data is waiting, and NONE otherwise. Neither direction touches the toggles.
- R11: A non-isochronous OUT with no buffer room, or IN with no transmit data waiting, gets NAK (2) and changes no toggle.
- R12: A non-isochronous IN with data waiting gets DATA with the transmit toggle as PID. A host-ACK event (kind 3) on an enabled, unstalled, non-isochronous endpoint flips the transmit toggle. A host-ACK event always gets NONE.
- R13: The token stream is ready whenever no response is held or the response is being taken. An accepted token produces its response on the next cycle. A held response stays unchanged until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Endpoint word write strobe |
| cfg_wr_ep | input | EPW | Endpoint written |
| cfg_wr_data | input | 32 | Write data, layout per R2 |
| cfg_rd_ep | input | EPW | Endpoint read |
| cfg_rd_data | output | 32 | Read data for cfg_rd_ep |
| ep_setup_stat | input | NUM_EP | Setup-status flag per endpoint |
| ep_rx_room | input | NUM_EP | Receive buffer has room |
| ep_tx_avail | input | NUM_EP | Transmit data is waiting |
| tok_valid | input | 1 | Token event valid |
| tok_ready | output | 1 | Token event accepted |
| tok_kind | input | 2 | 0 SETUP, 1 OUT data, 2 IN, 3 host ACK |
| tok_ep | input | EPW | Endpoint of the token |
| tok_pid | input | 1 | Received data PID (0 DATA0, 1 DATA1) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_code | output | 3 | 0 NONE, 1 ACK, 2 NAK, 3 STALL, 4 DATA |
| rsp_keep | output | 1 | Received data is kept |
| rsp_pid | output | 1 | Data PID for the transaction |

## Verification
A toggle that holds the wrong value shows up on the very next OUT or IN to that endpoint. It appears either as a response PID that differs from the expected one, or as a correct-PID packet that is dropped. A stall flag that holds the wrong value shows the next cycle in the endpoint word, and on the next transaction as STALL where DATA or ACK was due, or the reverse. The sweeps run every combination of type, enable, inhibit, buffer state and PID on every endpoint. They carry a toggle model across the whole run, so a single missed or extra flip makes every later PID check on that endpoint disagree.

// File: rtl/usb_ephs_pkg.sv
package usb_ephs_pkg;

  localparam int CFG_DW = 32;

  localparam int B_RX_EN    = 0;
  localparam int B_RX_TYPE  = 1;
  localparam int B_RX_INH   = 3;
  localparam int B_RX_STALL = 4;
  localparam int B_RX_TRST  = 5;
  localparam int B_TX_EN    = 8;
  localparam int B_TX_TYPE  = 9;
  localparam int B_TX_STALL = 11;
  localparam int B_TX_TRST  = 12;

  typedef enum logic [1:0] {
    EPT_CTRL = 2'd0,
    EPT_ISO  = 2'd1,
    EPT_BULK = 2'd2,
    EPT_INTR = 2'd3
  } ep_type_e;

  typedef enum logic [1:0] {
    TK_SETUP = 2'd0,
    TK_OUT   = 2'd1,
    TK_IN    = 2'd2,
    TK_HACK  = 2'd3
  } tok_kind_e;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_DATA  = 3'd4
  } rsp_code_e;

  typedef struct packed {
    logic     rx_en;
    ep_type_e rx_type;
    logic     rx_inh;
    logic     rx_stall;
    logic     tx_en;
    ep_type_e tx_type;
    logic     tx_stall;
  } ep_cfg_t;

  function automatic ep_cfg_t cfg_unpack(input logic [CFG_DW-1:0] w);
    ep_cfg_t c;
    c.rx_en    = w[B_RX_EN];
    c.rx_type  = ep_type_e'(w[B_RX_TYPE +: 2]);
    c.rx_inh   = w[B_RX_INH];
    c.rx_stall = w[B_RX_STALL];
    c.tx_en    = w[B_TX_EN];
    c.tx_type  = ep_type_e'(w[B_TX_TYPE +: 2]);
    c.tx_stall = w[B_TX_STALL];
    return c;
  endfunction

  function automatic logic [CFG_DW-1:0] cfg_pack(input ep_cfg_t c);
    logic [CFG_DW-1:0] w;
    w                   = '0;
    w[B_RX_EN]          = c.rx_en;
    w[B_RX_TYPE +: 2]   = c.rx_type;
    w[B_RX_INH]         = c.rx_inh;
    w[B_RX_STALL]       = c.rx_stall;
    w[B_TX_EN]          = c.tx_en;
    w[B_TX_TYPE +: 2]   = c.tx_type;
    w[B_TX_STALL]       = c.tx_stall;
    return w;
  endfunction

endpackage

// File: rtl/usb_ephs_regs.sv
module usb_ephs_regs
  import usb_ephs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EPW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EPW-1:0]    wr_ep,
  input  logic [CFG_DW-1:0] wr_data,
  input  logic [NUM_EP-1:0] setup_hit,
  input  logic [NUM_EP-1:0] setup_stat,
  output ep_cfg_t           cfg_q [NUM_EP],
  output logic [NUM_EP-1:0] rx_trst,
  output logic [NUM_EP-1:0] tx_trst
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    ep_cfg_t cur;
    ep_cfg_t nxt;
    logic    sel;
    logic    release_now;

    assign sel         = wr_en && (wr_ep == EPW'(i));
    assign release_now = setup_hit[i] || setup_stat[i];

    always_comb begin
      nxt = cur;
      if (sel) begin
        nxt = cfg_unpack(wr_data);
      end
      // a pending or arriving setup overrides any stall on control directions
      if (release_now && (nxt.rx_type == EPT_CTRL)) begin
        nxt.rx_stall = 1'b0;
      end
      if (release_now && (nxt.tx_type == EPT_CTRL)) begin
        nxt.tx_stall = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur <= '0;
      end else begin
        cur <= nxt;
      end
    end

    assign cfg_q[i]   = cur;
    assign rx_trst[i] = sel && wr_data[B_RX_TRST];
    assign tx_trst[i] = sel && wr_data[B_TX_TRST];
  end

endmodule

// File: rtl/usb_ephs_toggle.sv
module usb_ephs_toggle #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] rx_trst,
  input  logic [NUM_EP-1:0] tx_trst,
  input  logic [NUM_EP-1:0] setup_hit,
  input  logic [NUM_EP-1:0] rx_flip,
  input  logic [NUM_EP-1:0] tx_flip,
  output logic [NUM_EP-1:0] rx_tgl,
  output logic [NUM_EP-1:0] tx_tgl
);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_tgl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_tgl[i] <= 1'b0;
        tx_tgl[i] <= 1'b0;
      end else begin
        if (rx_trst[i]) begin
          rx_tgl[i] <= 1'b0;
        end else if (setup_hit[i]) begin
          rx_tgl[i] <= 1'b1;
        end else if (rx_flip[i]) begin
          rx_tgl[i] <= ~rx_tgl[i];
        end
        if (tx_trst[i]) begin
          tx_tgl[i] <= 1'b0;
        end else if (setup_hit[i]) begin
          tx_tgl[i] <= 1'b1;
        end else if (tx_flip[i]) begin
          tx_tgl[i] <= ~tx_tgl[i];
        end
      end
    end
  end

endmodule

// File: rtl/usb_ephs_decide.sv
module usb_ephs_decide
  import usb_ephs_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EPW    = 2
) (
  input  logic              tok_fire,
  input  tok_kind_e         tok_kind,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              tok_pid,
  input  ep_cfg_t           cfg_q [NUM_EP],
  input  logic [NUM_EP-1:0] rx_tgl,
  input  logic [NUM_EP-1:0] tx_tgl,
  input  logic [NUM_EP-1:0] rx_room,
  input  logic [NUM_EP-1:0] tx_avail,
  output rsp_code_e         code,
  output logic              keep,
  output logic              pid_out,
  output logic [NUM_EP-1:0] setup_hit,
  output logic [NUM_EP-1:0] rx_flip,
  output logic [NUM_EP-1:0] tx_flip
);

  ep_cfg_t c;
  logic    rt;
  logic    tt;
  logic    room;
  logic    avail;

  assign c     = cfg_q[tok_ep];
  assign rt    = rx_tgl[tok_ep];
  assign tt    = tx_tgl[tok_ep];
  assign room  = rx_room[tok_ep];
  assign avail = tx_avail[tok_ep];

  always_comb begin
    code      = RSP_NONE;
    keep      = 1'b0;
    pid_out   = 1'b0;
    setup_hit = '0;
    rx_flip   = '0;
    tx_flip   = '0;
    unique case (tok_kind)
      TK_SETUP: begin
        if (c.rx_en && (c.rx_type == EPT_CTRL)) begin
          code              = RSP_ACK;
          keep              = 1'b1;
          setup_hit[tok_ep] = tok_fire;
        end
      end
      TK_OUT: begin
        pid_out = rt;
        if (c.rx_en) begin
          if (c.rx_type == EPT_ISO) begin
            keep = room;
          end else if (c.rx_stall) begin
            code = RSP_STALL;
          end else if (!room) begin
            code = RSP_NAK;
          end else begin
            code = RSP_ACK;
            if (c.rx_inh) begin
              keep = 1'b1;
            end else if (tok_pid == rt) begin
              keep            = 1'b1;
              rx_flip[tok_ep] = tok_fire;
            end
          end
        end
      end
      TK_IN: begin
        pid_out = tt;
        if (c.tx_en) begin
          if (c.tx_type == EPT_ISO) begin
            pid_out = 1'b0;
            if (avail) code = RSP_DATA;
          end else if (c.tx_stall) begin
            code = RSP_STALL;
          end else if (!avail) begin
            code = RSP_NAK;
          end else begin
            code = RSP_DATA;
          end
        end
      end
      TK_HACK: begin
        pid_out = tt;
        if (c.tx_en && (c.tx_type != EPT_ISO) && !c.tx_stall) begin
          tx_flip[tok_ep] = tok_fire;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_ephs_pkg::*;
#(
  parameter  int NUM_EP = 4,
  localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [EPW-1:0]    cfg_wr_ep,
  input  logic [31:0]       cfg_wr_data,
  input  logic [EPW-1:0]    cfg_rd_ep,
  output logic [31:0]       cfg_rd_data,
  input  logic [NUM_EP-1:0] ep_setup_stat,
  input  logic [NUM_EP-1:0] ep_rx_room,
  input  logic [NUM_EP-1:0] ep_tx_avail,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [1:0]        tok_kind,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              tok_pid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_code,
  output logic              rsp_keep,
  output logic              rsp_pid
);

  ep_cfg_t           cfg_q [NUM_EP];
  logic [NUM_EP-1:0] rx_trst;
  logic [NUM_EP-1:0] tx_trst;
  logic [NUM_EP-1:0] setup_hit;
  logic [NUM_EP-1:0] rx_flip;
  logic [NUM_EP-1:0] tx_flip;
  logic [NUM_EP-1:0] rx_tgl;
  logic [NUM_EP-1:0] tx_tgl;
  logic              tok_fire;
  rsp_code_e         dec_code;
  logic              dec_keep;
  logic              dec_pid;

  assign tok_ready = !rsp_valid || rsp_ready;
  assign tok_fire  = tok_valid && tok_ready;

  usb_ephs_regs #(.NUM_EP(NUM_EP), .EPW(EPW)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_ep      (cfg_wr_ep),
    .wr_data    (cfg_wr_data),
    .setup_hit  (setup_hit),
    .setup_stat (ep_setup_stat),
    .cfg_q      (cfg_q),
    .rx_trst    (rx_trst),
    .tx_trst    (tx_trst)
  );

  usb_ephs_toggle #(.NUM_EP(NUM_EP)) i_toggle (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_trst   (rx_trst),
    .tx_trst   (tx_trst),
    .setup_hit (setup_hit),
    .rx_flip   (rx_flip),
    .tx_flip   (tx_flip),
    .rx_tgl    (rx_tgl),
    .tx_tgl    (tx_tgl)
  );

  usb_ephs_decide #(.NUM_EP(NUM_EP), .EPW(EPW)) i_decide (
    .tok_fire  (tok_fire),
    .tok_kind  (tok_kind_e'(tok_kind)),
    .tok_ep    (tok_ep),
    .tok_pid   (tok_pid),
    .cfg_q     (cfg_q),
    .rx_tgl    (rx_tgl),
    .tx_tgl    (tx_tgl),
    .rx_room   (ep_rx_room),
    .tx_avail  (ep_tx_avail),
    .code      (dec_code),
    .keep      (dec_keep),
    .pid_out   (dec_pid),
    .setup_hit (setup_hit),
    .rx_flip   (rx_flip),
    .tx_flip   (tx_flip)
  );

  // one-deep response slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_NONE;
      rsp_keep  <= 1'b0;
      rsp_pid   <= 1'b0;
    end else if (tok_ready) begin
      rsp_valid <= tok_valid;
      if (tok_valid) begin
        rsp_code <= dec_code;
        rsp_keep <= dec_keep;
        rsp_pid  <= dec_pid;
      end
    end
  end

  assign cfg_rd_data = cfg_pack(cfg_q[cfg_rd_ep]);

endmodule

// File: rtl/usb_ephs_chk.sv
module usb_ephs_chk
  import usb_ephs_pkg::*;
#(
  parameter  int NUM_EP = 4,
  localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [EPW-1:0]    cfg_wr_ep,
  input logic [NUM_EP-1:0] ep_setup_stat,
  input logic [NUM_EP-1:0] ep_rx_room,
  input logic              tok_valid,
  input logic              tok_ready,
  input logic [1:0]        tok_kind,
  input logic [EPW-1:0]    tok_ep,
  input logic              tok_pid,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [2:0]        rsp_code,
  input logic              rsp_keep,
  input logic              rsp_pid,
  input ep_cfg_t           cfg_q [NUM_EP],
  input logic [NUM_EP-1:0] rx_tgl,
  input logic [NUM_EP-1:0] tx_tgl
);

  logic fire;
  assign fire = tok_valid && tok_ready;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_keep) && $stable(rsp_pid)); // R13

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid); // R13

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tok_kind == TK_OUT && !cfg_q[tok_ep].rx_en |=> rsp_code == RSP_NONE && !rsp_keep); // R3

  AST_ISO_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tok_kind == TK_OUT && cfg_q[tok_ep].rx_type == EPT_ISO |=> rsp_code == RSP_NONE); // R10

  AST_WRONG_PID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tok_kind == TK_OUT && cfg_q[tok_ep].rx_en && cfg_q[tok_ep].rx_type != EPT_ISO
    && !cfg_q[tok_ep].rx_stall && !cfg_q[tok_ep].rx_inh && ep_rx_room[tok_ep]
    && tok_pid != rx_tgl[tok_ep] |=> rsp_code == RSP_ACK && !rsp_keep); // R4

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep_chk
    AST_HOLD_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      ep_setup_stat[i] |=> cfg_q[i].tx_type != EPT_CTRL || !cfg_q[i].tx_stall); // R9

    AST_HOLD_RX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      ep_setup_stat[i] |=> cfg_q[i].rx_type != EPT_CTRL || !cfg_q[i].rx_stall); // R9

    AST_SETUP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      fire && tok_kind == TK_SETUP && tok_ep == EPW'(i) && cfg_q[i].rx_en
      && cfg_q[i].rx_type == EPT_CTRL && !(cfg_wr_en && cfg_wr_ep == EPW'(i))
      |=> rx_tgl[i] && tx_tgl[i]); // R8
  end

endmodule

bind usb_ep_handshake usb_ephs_chk #(.NUM_EP(NUM_EP)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_wr_ep     (cfg_wr_ep),
  .ep_setup_stat (ep_setup_stat),
  .ep_rx_room    (ep_rx_room),
  .tok_valid     (tok_valid),
  .tok_ready     (tok_ready),
  .tok_kind      (tok_kind),
  .tok_ep        (tok_ep),
  .tok_pid       (tok_pid),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_code      (rsp_code),
  .rsp_keep      (rsp_keep),
  .rsp_pid       (rsp_pid),
  .cfg_q         (cfg_q),
  .rx_tgl        (rx_tgl),
  .tx_tgl        (tx_tgl)
);

// File: tb/test_usb_ep_handshake.sv
module test_usb_ep_handshake;

  localparam int CLK_PERIOD = 10;
  localparam int NEP        = 4;
  localparam int EW         = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_wr_en = 1'b0;
  logic [EW-1:0]   cfg_wr_ep = '0;
  logic [31:0]     cfg_wr_data = '0;
  logic [EW-1:0]   cfg_rd_ep = '0;
  logic [31:0]     cfg_rd_data;
  logic [NEP-1:0]  ep_setup_stat = '0;
  logic [NEP-1:0]  ep_rx_room = '0;
  logic [NEP-1:0]  ep_tx_avail = '0;
  logic            tok_valid = 1'b0;
  logic            tok_ready;
  logic [1:0]      tok_kind = '0;
  logic [EW-1:0]   tok_ep = '0;
  logic            tok_pid = 1'b0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [2:0]      rsp_code;
  logic            rsp_keep;
  logic            rsp_pid;

  int n_chk  = 0;
  int n_fail = 0;
  bit rx_m [NEP];
  bit tx_m [NEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_handshake #(.NUM_EP(NEP)) i_usb_ep_handshake (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_ep(cfg_wr_ep), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_ep(cfg_rd_ep), .cfg_rd_data(cfg_rd_data),
    .ep_setup_stat(ep_setup_stat), .ep_rx_room(ep_rx_room), .ep_tx_avail(ep_tx_avail),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_kind(tok_kind),
    .tok_ep(tok_ep), .tok_pid(tok_pid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_keep(rsp_keep), .rsp_pid(rsp_pid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input int ep, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_ep = EW'(ep); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input int ep, output int d);
    cfg_rd_ep = EW'(ep);
    #1;
    d = int'(cfg_rd_data);
  endtask

  task automatic tok(input int kind, input int ep, input bit pid,
                     output int code, output int keep, output int p);
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = 2'(kind); tok_ep = EW'(ep); tok_pid = pid;
    @(negedge clk);
    tok_valid = 1'b0;
    chk("R13 response one cycle after token", int'(rsp_valid), 1);
    code = int'(rsp_code); keep = int'(rsp_keep); p = int'(rsp_pid);
  endtask

  function automatic void exp_out(input bit en, input int ty, input bit inh, input bit stall,
                                  input bit room, input bit pid, input bit tgl,
                                  output int code, output int keep, output bit flip);
    code = 0; keep = 0; flip = 1'b0;
    if (!en) return;
    if (ty == 1) begin keep = int'(room); return; end
    if (stall) begin code = 3; return; end
    if (!room) begin code = 2; return; end
    code = 1;
    if (inh) keep = 1;
    else if (pid == tgl) begin keep = 1; flip = 1'b1; end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int c, k, p, d, ec, ek;
    bit fl;
    string tag;
    for (int i = 0; i < NEP; i++) begin rx_m[i] = 1'b0; tx_m[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 no response pending", int'(rsp_valid), 0);
    for (int e = 0; e < NEP; e++) begin
      rd(e, d);
      chk("R1 endpoint word", d, 0);
    end
    ep_rx_room = '1;
    tok(1, 0, 1'b0, c, k, p);
    chk("R1 disabled after reset", c, 0);

    // R2: readback masks reserved and toggle-reset bits
    wr(2, 32'hFFFF_FFFF);
    rd(2, d);
    chk("R2 readback mask", d, 32'h0000_0F1F);
    wr(2, 32'h0);
    rd(2, d);
    chk("R2 cleared", d, 0);

    // OUT sweep: R3 R4 R5 R10 R11
    for (int e = 0; e < NEP; e++) begin
      for (int ty = 0; ty < 4; ty++) begin
        for (int en = 0; en < 2; en++) begin
          for (int inh = 0; inh < 2; inh++) begin
            for (int rm = 0; rm < 2; rm++) begin
              for (int pd = 0; pd < 2; pd++) begin
                wr(e, 32'(en | (ty << 1) | (inh << 3)));
                ep_rx_room[e] = rm[0];
                exp_out(en[0], ty, inh[0], 1'b0, rm[0], pd[0], rx_m[e], ec, ek, fl);
                tok(1, e, pd[0], c, k, p);
                if (en == 0) tag = "R3";
                else if (ty == 1) tag = "R10";
                else if (rm == 0) tag = "R11";
                else if (inh == 1) tag = "R5";
                else tag = "R4";
                chk({tag, " OUT code"}, c, ec);
                chk({tag, " OUT keep"}, k, ek);
                chk("R4 OUT expected pid", p, int'(rx_m[e]));
                rx_m[e] = rx_m[e] ^ fl;
              end
            end
          end
        end
      end
      ep_rx_room[e] = 1'b1;
    end

    // IN sweep: R3 R10 R11 R12
    for (int e = 0; e < NEP; e++) begin
      for (int ty = 0; ty < 4; ty++) begin
        for (int en = 0; en < 2; en++) begin
          for (int av = 0; av < 2; av++) begin
            wr(e, 32'((en << 8) | (ty << 9)));
            ep_tx_avail[e] = av[0];
            if (en == 0) begin ec = 0; tag = "R3"; end
            else if (ty == 1) begin ec = (av == 1) ? 4 : 0; tag = "R10"; end
            else if (av == 0) begin ec = 2; tag = "R11"; end
            else begin ec = 4; tag = "R12"; end
            tok(2, e, 1'b0, c, k, p);
            chk({tag, " IN code"}, c, ec);
            if (ec == 4) chk({tag, " IN pid"}, p, (ty == 1) ? 0 : int'(tx_m[e]));
            tok(3, e, 1'b0, c, k, p);
            chk("R12 host ack gets no handshake", c, 0);
            if (en == 1 && ty != 1) tx_m[e] = ~tx_m[e];
          end
        end
      end
      ep_tx_avail[e] = 1'b1;
    end

    // R6: toggle reset, both directions, on endpoint 3 (bulk)
    wr(3, 32'h0000_0025);
    rx_m[3] = 1'b0;
    tok(1, 3, 1'b0, c, k, p);
    chk("R6 DATA0 accepted after reset", k, 1);
    wr(3, 32'h0000_0025);
    tok(1, 3, 1'b1, c, k, p);
    chk("R6 DATA1 dropped after reset", k, 0);
    chk("R6 rx pid back to DATA0", p, 0);
    rd(3, d);
    chk("R2 toggle-reset bits read 0", d, 32'h5);
    wr(3, 32'h0000_1500);
    tok(2, 3, 1'b0, c, k, p);
    chk("R6 tx pid back to DATA0", p, 0);
    tok(3, 3, 1'b0, c, k, p);
    tok(2, 3, 1'b0, c, k, p);
    chk("R12 tx toggle flipped by host ack", p, 1);

    // R7 R8 R9: stall, SETUP auto-clear, hold window, re-stall
    wr(1, 32'h0000_0911);
    rd(1, d);
    chk("R7 stall bits set", d, 32'h911);
    tok(2, 1, 1'b0, c, k, p);
    chk("R7 IN stalled", c, 3);
    tok(1, 1, 1'b0, c, k, p);
    chk("R7 OUT stalled", c, 3);
    tok(2, 1, 1'b0, c, k, p);
    chk("R7 stall persists", c, 3);
    tok(0, 1, 1'b0, c, k, p);
    chk("R8 SETUP acked", c, 1);
    chk("R8 SETUP data kept", k, 1);
    rd(1, d);
    chk("R8 stalls cleared by SETUP", d, 32'h101);
    tok(2, 1, 1'b0, c, k, p);
    chk("R8 IN after SETUP", c, 4);
    chk("R8 tx pid DATA1 after SETUP", p, 1);
    tok(1, 1, 1'b1, c, k, p);
    chk("R8 rx expects DATA1 after SETUP", k, 1);
    ep_setup_stat[1] = 1'b1;
    wr(1, 32'h0000_0911);
    rd(1, d);
    chk("R9 re-stall overridden while flag set", d, 32'h101);
    tok(2, 1, 1'b0, c, k, p);
    chk("R9 IN not stalled while flag set", c, 4);
    ep_setup_stat[1] = 1'b0;
    wr(1, 32'h0000_0911);
    rd(1, d);
    chk("R9 re-stall sticks after flag drops", d, 32'h911);
    tok(2, 1, 1'b0, c, k, p);
    chk("R9 IN stalled after flag drops", c, 3);
    @(negedge clk);
    ep_setup_stat[1] = 1'b1;
    @(negedge clk);
    rd(1, d);
    chk("R9 rising flag clears existing stall", d, 32'h101);
    ep_setup_stat[1] = 1'b0;

    // R8: SETUP on a bulk endpoint is ignored
    wr(0, 32'h0000_0015);
    tok(0, 0, 1'b0, c, k, p);
    chk("R8 SETUP on bulk ignored", c, 0);
    rd(0, d);
    chk("R8 bulk stall untouched", d, 32'h15);
    tok(1, 0, 1'b0, c, k, p);
    chk("R7 bulk OUT stalled", c, 3);

    // R13: back-pressure on the response stream
    wr(0, 32'h0000_0005);
    rsp_ready = 1'b0;
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = 2'd1; tok_ep = 2'd0; tok_pid = rx_m[0];
    @(negedge clk);
    tok_kind = 2'd2; tok_pid = 1'b0;
    chk("R13 first response", int'(rsp_code), 1);
    chk("R13 token stalled", int'(tok_ready), 0);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      chk("R13 response held", int'(rsp_code), 1);
      chk("R13 response keep held", int'(rsp_keep), 1);
      chk("R13 token still stalled", int'(tok_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    tok_valid = 1'b0;
    chk("R13 second response valid", int'(rsp_valid), 1);
    chk("R13 second response", int'(rsp_code), 0);
    @(negedge clk);
    chk("R13 drained", int'(rsp_valid), 0);

    summary();
  end

endmodule